// File: doc/BRIEF.md
# Microstep Phase Indexer

This block turns a step-and-direction command stream into per-coil current setpoints for a two-phase bipolar stepper motor. It holds an electrical position made of a quadrant number and an index within the quarter wave. Each rising edge of the step input moves that position by one microstep, either forward or backward. The size of the microstep is set by one of eight resolutions. Six of the resolutions are binary and share one fine quarter-sine table. The 1/10 and 1/20 resolutions use a separate 20-entry table.

For each coil the block outputs a magnitude in percent of full current, a polarity bit and a drive enable. Downstream current regulation consumes these values. The block also drives an active-low flag that shows when the motor sits at the home position. Three level qualifiers control the block: a standby input clears everything, a zero input pins the position at home, and an output-enable input gates the drives without stopping the position from moving.

Top module: `microstep_indexer`

## Requirements
- R1: `mode` selects how many microsteps make up one quarter of the electrical cycle: 000 gives 2, 001 gives 8, 010 gives 16, 011 gives 32, 100 gives 64, 101 gives 128, 110 gives 10 and 111 gives 20. The value is captured only while `zero_n` or `sleep_n` is low.
- R2: A rising edge on `step` moves the position by exactly one microstep. The outputs change on the third rising clock edge after the edge on `step`. A `step` held high moves the position only once, and with no edge the position holds.
- R3: With `dir` = 0 the electrical angle φ increases, so coil 2 lags coil 1 by 90 degrees. With `dir` = 1 the angle decreases, so coil 2 leads.
- R4: The magnitudes are `c1_mag` = round(100·|cos φ|) and `c2_mag` = round(100·|sin φ|), where φ = position·90°/(steps per quarter). The polarity bit is 1 when the current is negative (cos φ < 0 for coil 1, sin φ < 0 for coil 2). Polarity carries meaning only when the magnitude is nonzero.
- R5: At home, `c1_mag` = 100 with positive polarity and `c2_mag` = 0. `home_n` is 0 exactly when the position is home.
- R6: While `zero_n` is low, the position is held at home, and `step` and `dir` have no effect.
- R7: While `oe` is low, `c1_en` and `c2_en` are 0, but step edges still move the position. When `oe` goes high, the outputs show the moved position.
- R8: While `sleep_n` is low, both enables are 0 and the position is home.
- R9: In every state, c1_mag² + c2_mag² lies between 9800 and 10200.
- R10: A change on `mode` while `zero_n` and `sleep_n` are both high does not change the step size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sleep_n | input | 1 | Standby, active low: clears the position and disables the drives |
| zero_n | input | 1 | Hold at home, active low; also the window in which `mode` is captured |
| oe | input | 1 | Drive enable for both coils |
| dir | input | 1 | Direction: 0 counts the angle up, 1 counts it down |
| step | input | 1 | Asynchronous step command; each rising edge is one microstep |
| mode | input | 3 | Resolution select |
| c1_en | output | 1 | Coil 1 drive enable |
| c1_neg | output | 1 | Coil 1 polarity, 1 = negative |
| c1_mag | output | 7 | Coil 1 magnitude in percent |
| c2_en | output | 1 | Coil 2 drive enable |
| c2_neg | output | 1 | Coil 2 polarity, 1 = negative |
| c2_mag | output | 7 | Coil 2 magnitude in percent |
| home_n | output | 1 | Low at the home position |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the following:
- the current-vector length bound;
- that the position holds when no edge arrives, and that it always changes when a qualified edge arrives;
- that the home state follows any cycle with `zero_n` or `sleep_n` low;
- that the captured resolution stays frozen while the block runs.

Other behaviour can only be shown by the bench scenarios, because they compare values against an independent trigonometric model. These cover:
- the exact magnitudes and polarities in each resolution;
- wrapping across quadrants in both directions;
- the three-edge latency;
- advancing under a disabled output;
- ignoring held-high step inputs and mode changes made while the block runs.

// File: rtl/microstep_indexer.sv
module microstep_indexer #(
  parameter int FINE_Q = 128,
  parameter int DEC_Q  = 20,
  parameter int MAG_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_n,
  input  logic             zero_n,
  input  logic             oe,
  input  logic             dir,
  input  logic             step,
  input  logic [2:0]       mode,
  output logic             c1_en,
  output logic             c1_neg,
  output logic [MAG_W-1:0] c1_mag,
  output logic             c2_en,
  output logic             c2_neg,
  output logic [MAG_W-1:0] c2_mag,
  output logic             home_n
);

  localparam int IW = $clog2(FINE_Q + 1);

  // round(100 * sin(k * 90deg / q)) in fixed point, scale 1e9
  function automatic int sin_pct(input int k, input int q);
    longint sc, x, term, sum;
    sc   = 64'sd1000000000;
    x    = longint'(k) * 64'sd3141592654 / longint'(2 * q);
    term = x;
    sum  = x;
    for (int i = 1; i < 10; i++) begin
      term = term * x / sc;
      term = term * x / sc;
      term = -term / longint'((2 * i) * (2 * i + 1));
      sum  = sum + term;
    end
    return int'((sum * 100 + sc / 2) / sc);
  endfunction

  logic [MAG_W-1:0] rom_f [0:FINE_Q];
  logic [MAG_W-1:0] rom_d [0:FINE_Q];

  for (genvar k = 0; k <= FINE_Q; k++) begin : g_rom
    assign rom_f[k] = MAG_W'(sin_pct(k, FINE_Q));
    if (k <= DEC_Q) begin : g_dec
      assign rom_d[k] = MAG_W'(sin_pct(k, DEC_Q));
    end else begin : g_pad
      assign rom_d[k] = '0;
    end
  end

  logic          s1, s2, s3;
  logic [2:0]    mode_q;
  logic [1:0]    quad;
  logic [IW-1:0] idx;
  logic [IW-1:0] stride, qlen, nidx, cidx;
  logic [IW:0]   sum;
  logic [1:0]    nquad;
  logic          rise, dec, run;
  logic [MAG_W-1:0] sin_t, cos_t;

  assign rise = s2 & ~s3;
  assign run  = sleep_n & zero_n;
  assign dec  = mode_q[2] & mode_q[1];
  assign qlen = dec ? IW'(DEC_Q) : IW'(FINE_Q);

  always_comb begin
    case (mode_q)
      3'd0:    stride = IW'(FINE_Q / 2);
      3'd1:    stride = IW'(FINE_Q / 8);
      3'd2:    stride = IW'(FINE_Q / 16);
      3'd3:    stride = IW'(FINE_Q / 32);
      3'd4:    stride = IW'(FINE_Q / 64);
      3'd5:    stride = IW'(FINE_Q / 128);
      3'd6:    stride = IW'(DEC_Q / 10);
      default: stride = IW'(1);
    endcase
  end

  always_comb begin
    nquad = quad;
    if (!dir) begin
      sum = {1'b0, idx} + {1'b0, stride};
      if (sum >= {1'b0, qlen}) begin
        sum   = sum - {1'b0, qlen};
        nquad = quad + 2'd1;
      end
    end else begin
      if (idx >= stride) begin
        sum = {1'b0, idx} - {1'b0, stride};
      end else begin
        sum   = {1'b0, idx} + {1'b0, qlen} - {1'b0, stride};
        nquad = quad - 2'd1;
      end
    end
    nidx = sum[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      s3     <= 1'b0;
      mode_q <= 3'd0;
      quad   <= 2'd0;
      idx    <= '0;
    end else begin
      s1 <= step;
      s2 <= s1;
      s3 <= s2;
      if (!run) begin
        mode_q <= mode;
        quad   <= 2'd0;
        idx    <= '0;
      end else if (rise) begin
        quad <= nquad;
        idx  <= nidx;
      end
    end
  end

  assign cidx   = qlen - idx;
  assign sin_t  = dec ? rom_d[idx]  : rom_f[idx];
  assign cos_t  = dec ? rom_d[cidx] : rom_f[cidx];
  assign c1_mag = quad[0] ? sin_t : cos_t;
  assign c2_mag = quad[0] ? cos_t : sin_t;
  assign c1_neg = quad[0] ^ quad[1];
  assign c2_neg = quad[1];
  assign c1_en  = oe & sleep_n;
  assign c2_en  = oe & sleep_n;
  assign home_n = (quad != 2'd0) || (idx != '0);

  assert_vector_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(c1_mag) * 32'(c1_mag) + 32'(c2_mag) * 32'(c2_mag)) >= 32'd9800) &&
    ((32'(c1_mag) * 32'(c1_mag) + 32'(c2_mag) * 32'(c2_mag)) <= 32'd10200));

  assert_hold_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rise) |=> ($stable(quad) && $stable(idx)));

  assert_edge_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rise) |=> !($stable(quad) && $stable(idx)));

  assert_home_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_n || !sleep_n) |=> (!home_n && c1_mag == MAG_W'(100) && c2_mag == '0 && !c1_neg));

  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_q));

endmodule

// File: tb/microstep_indexer_tb.sv
module microstep_indexer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, sleep_n = 1'b1, zero_n = 1'b1, oe = 1'b1, dir = 1'b0, step = 1'b0;
  logic [2:0] mode = 3'd0;
  logic c1_en, c1_neg, c2_en, c2_neg, home_n;
  logic [6:0] c1_mag, c2_mag;

  always #2.5 clk = ~clk;

  microstep_indexer u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .zero_n(zero_n), .oe(oe),
    .dir(dir), .step(step), .mode(mode),
    .c1_en(c1_en), .c1_neg(c1_neg), .c1_mag(c1_mag),
    .c2_en(c2_en), .c2_neg(c2_neg), .c2_mag(c2_mag), .home_n(home_n)
  );

  typedef struct {
    string tag;
    int    m1, m2;
    bit    n1, n2, en, hn;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  int mode_m = 0, pos_m = 0;
  bit run_m = 1'b1;

  function automatic int per_q(input int m);
    case (m)
      0: return 2;   1: return 8;   2: return 16;  3: return 32;
      4: return 64;  5: return 128; 6: return 10;  default: return 20;
    endcase
  endfunction

  task automatic chk(input string tag);
    item_t it;
    real ph, c, s;
    int n;
    n  = 4 * per_q(mode_m);
    ph = 2.0 * 3.14159265358979 * real'(pos_m) / real'(n);
    c  = $cos(ph);
    s  = $sin(ph);
    it.tag = tag;
    it.m1  = $rtoi((c < 0.0 ? -c : c) * 100.0 + 0.5);
    it.m2  = $rtoi((s < 0.0 ? -s : s) * 100.0 + 0.5);
    it.n1  = c < 0.0;
    it.n2  = s < 0.0;
    it.en  = oe && sleep_n;
    it.hn  = pos_m != 0;
    @(posedge clk);
    q.push_back(it);
    wait (q.size() == 0);
    #1;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      bit bad;
      e = q.pop_front();
      checks++;
      bad = (c1_mag != 7'(e.m1)) || (c2_mag != 7'(e.m2)) ||
            (e.m1 != 0 && c1_neg != e.n1) || (e.m2 != 0 && c2_neg != e.n2) ||
            (c1_en != e.en) || (c2_en != e.en) || (home_n != e.hn);
      if (bad) begin
        errors++;
        $display("FAIL %s: actual c1=%0d/%0b c2=%0d/%0b en=%0b%0b home_n=%0b expected c1=%0d/%0b c2=%0d/%0b en=%0b home_n=%0b",
                 e.tag, c1_mag, c1_neg, c2_mag, c2_neg, c1_en, c2_en, home_n,
                 e.m1, e.n1, e.m2, e.n2, e.en, e.hn);
      end
    end
  end

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) step = 1'b1;
      repeat (3) @(negedge clk);
      step = 1'b0;
      repeat (3) @(negedge clk);
      if (run_m) begin
        pos_m = pos_m + (dir ? -1 : 1);
        pos_m = (pos_m + 4 * per_q(mode_m)) % (4 * per_q(mode_m));
      end
    end
  endtask

  task automatic load_mode(input int m);
    @(negedge clk);
    zero_n = 1'b0;
    mode   = 3'(m);
    repeat (2) @(negedge clk);
    zero_n = 1'b1;
    mode_m = m;
    pos_m  = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    load_mode(5);
    chk("R5 reset home");

    // R2 latency: no change before third edge
    @(negedge clk) step = 1'b1;
    @(posedge clk); @(posedge clk);
    #1;
    checks++;
    if (home_n !== 1'b0) begin
      errors++;
      $display("FAIL R2 early move: actual home_n=%0b expected 0", home_n);
    end
    @(posedge clk);
    #1;
    checks++;
    if (c2_mag !== 7'd1) begin
      errors++;
      $display("FAIL R2 third edge: actual c2=%0d expected 1", c2_mag);
    end
    repeat (2) @(negedge clk);
    step = 1'b0;
    repeat (3) @(negedge clk);
    pos_m = 1;
    chk("R2 fine step 1");

    for (int i = 0; i < 6; i++) begin
      pulse(1);
      chk("R4 fine forward R3");
    end

    load_mode(0);
    for (int i = 0; i < 8; i++) begin
      pulse(1);
      chk("R1 half step quadrant walk R4");
    end
    chk("R5 back at home");

    dir = 1'b1;
    pulse(1);
    chk("R3 reverse wraps below home");
    pulse(2);
    chk("R3 reverse half step");
    dir = 1'b0;

    load_mode(7);
    for (int i = 0; i < 25; i++) begin
      pulse(1);
      chk("R1 decimal 1/20 forward R4");
    end

    load_mode(6);
    dir = 1'b1;
    for (int i = 0; i < 12; i++) begin
      pulse(1);
      chk("R1 decimal 1/10 reverse R3");
    end
    dir = 1'b0;

    load_mode(1);
    pulse(3);
    oe = 1'b0;
    pulse(5);
    chk("R7 disabled drives still advance");
    oe = 1'b1;
    chk("R7 drives resume at moved position");

    mode = 3'd0;
    pulse(2);
    chk("R10 mode change ignored while running");
    mode = 3'd1;

    @(negedge clk) zero_n = 1'b0;
    run_m = 1'b0;
    pos_m = 0;
    dir = 1'b1;
    pulse(3);
    dir = 1'b0;
    pulse(2);
    chk("R6 zero hold ignores step and dir");
    zero_n = 1'b1;
    run_m = 1'b1;
    repeat (2) @(negedge clk);

    pulse(2);
    @(negedge clk) sleep_n = 1'b0;
    run_m = 1'b0;
    pos_m = 0;
    pulse(2);
    chk("R8 standby off and home");
    sleep_n = 1'b1;
    run_m = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 standby released at home");

    @(negedge clk) step = 1'b1;
    repeat (20) @(negedge clk);
    pos_m = 1;
    chk("R2 held step moves once");
    step = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 no edge no move");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule